// File: doc/BRIEF.md
# Three-Wire Control Register with Mode Select

This block is a control port that a baseband processor writes over three lines: serial data, serial clock and a latch strobe. Bits move into a shift register on each serial clock rising edge, most significant bit first. A rising edge on the latch strobe copies the last 24 bits shifted in into a control register. That register drives the synthesizer divider ratio, the comparison-frequency select, the test bit and the calibration enable.

Two fields of the control register decide where the operating mode and the auxiliary converter channel select come from. When a field is clear, the mode or the select follows the external pins. When it is set, it follows the matching serial bits. The effective sleep, FM and idle controls go through a fixed-priority decode into a 3-bit mode. A one-cycle pulse marks each entry into a CDMA mode.

All serial lines and pins are asynchronous to `clk`. Each one passes through a two-flop synchronizer before use. The reset is asynchronous and active low, and its release is synchronized to `clk`.

Top module: `serial_mode_ctl`

## Requirements
- R1: While reset is held, and after it is released with all inputs low, every output is zero: the divider is 0, all control bits are 0, the mode is 3'b000 (sleep), the channel select is 0 and there is no entry pulse.
- R2: Serial data is taken on each rising edge of the serial clock, most significant bit first. When more than 24 bits are shifted before a latch, only the last 24 take effect.
- R3: The control outputs (divider, comparison select, test, calibration enable) change only on a rising edge of the latch strobe. Serial clock activity without a latch edge leaves them unchanged.
- R4: The word layout, counted from bit 0, is:
  - bit 0: calibration enable (0 requests calibration)
  - bit 1: channel-select source
  - bits 3:2: serial channel select
  - bit 4: test (0 in normal use)
  - bit 5: FM control
  - bit 6: idle control
  - bit 7: sleep control
  - bit 8: mode source
  - bits 22:9: divider ratio
  - bit 23: comparison select (0 = 30 kHz, 1 = 5 kHz)
- R5: While the latched mode-source bit is 0, which is its value after reset, the mode follows the pins `pin_sleep_n`, `pin_fm_n` and `pin_idle_n`.
- R6: While the latched mode-source bit is 1, the mode follows serial bits 7, 6 and 5, and the mode pins have no effect.
- R7: The mode decode is fixed priority. A sleep control of 0 gives 3'b000 whatever the other two controls are. Otherwise the mode is {1, FM control, idle control}:
  - 3'b100: FM receive only
  - 3'b101: FM receive and transmit
  - 3'b110: CDMA receive only
  - 3'b111: CDMA receive and transmit
- R8: `aux_sel` follows `pin_aux_sel` while the latched channel-select source bit is 0, and follows serial bits 3:2 while it is 1.
- R9: `cdma_entry` is high for exactly one cycle when the mode changes from a non-CDMA value (sleep or FM) to 3'b110 or 3'b111. It stays low on a change between the two CDMA modes.
- R10: A change on a mode pin reaches `mode` at the third rising `clk` edge after it. The pin is registered at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Rising edge transfers the shifted word to the control register |
| pin_sleep_n | input | 1 | Sleep pin, 0 = sleep |
| pin_fm_n | input | 1 | FM pin, 0 = FM, 1 = CDMA |
| pin_idle_n | input | 1 | Idle pin, 0 = receive only |
| pin_aux_sel | input | SEL_W | Auxiliary channel select pins |
| div_ratio | output | DIV_W | Receive synthesizer divider ratio |
| cmp_slow | output | 1 | Comparison select, 1 = 5 kHz |
| test_mode | output | 1 | Test bit |
| cal_en | output | 1 | Calibration enable, 0 requests calibration |
| mode | output | 3 | Decoded operating mode |
| aux_sel | output | SEL_W | Effective auxiliary channel select |
| cdma_entry | output | 1 | One-cycle pulse on entry into a CDMA mode |

## Verification
The bench builds the block with its defaults: a 14-bit divider, a 2-bit channel select and two synchronizer stages, which gives a 24-bit word. At these values an over-long burst (30 bits) can be sent to show that only the last 24 bits count. The stimulus reaches every mode decode entry, including sleep overriding a CDMA pin setting. It also hands control over from pins to serial bits and back, and measures the pin-to-mode latency edge by edge.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;

  typedef enum logic [2:0] {
    MODE_SLEEP     = 3'b000,
    MODE_FM_RX     = 3'b100,
    MODE_FM_RXTX   = 3'b101,
    MODE_CDMA_RX   = 3'b110,
    MODE_CDMA_RXTX = 3'b111
  } op_mode_e;

  typedef struct packed {
    logic sleep_n;
    logic fm_n;
    logic idle_n;
  } mode_ctl_t;

  function automatic logic is_cdma(op_mode_e m);
    return (m == MODE_CDMA_RX) || (m == MODE_CDMA_RXTX);
  endfunction

endpackage

// File: rtl/smc_sync.sv
`timescale 1ns/1ps
module smc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/smc_shifter.sv
`timescale 1ns/1ps
module smc_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              slatch_s,
  output logic              load,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] sh_q, sh_d, word_d;
  logic              sclk_prev_q, latch_prev_q;
  logic              shift_en;

  assign shift_en = sclk_s & ~sclk_prev_q;
  assign load     = slatch_s & ~latch_prev_q;

  always_comb begin
    sh_d   = sh_q;
    word_d = word_q;
    if (shift_en) sh_d   = {sh_q[WORD_W-2:0], sdata_s};
    if (load)     word_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q         <= '0;
      word_q       <= '0;
      sclk_prev_q  <= 1'b0;
      latch_prev_q <= 1'b0;
    end else begin
      sh_q         <= sh_d;
      word_q       <= word_d;
      sclk_prev_q  <= sclk_s;
      latch_prev_q <= slatch_s;
    end
  end

endmodule

// File: rtl/smc_mode_dec.sv
`timescale 1ns/1ps
module smc_mode_dec
  import smc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_from_ser,
  input  mode_ctl_t        ser_ctl,
  input  mode_ctl_t        pin_ctl,
  input  logic             sel_from_ser,
  input  logic [SEL_W-1:0] ser_sel,
  input  logic [SEL_W-1:0] pin_sel,
  output op_mode_e         mode_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             entry_q
);

  mode_ctl_t        eff;
  op_mode_e         mode_d;
  logic [SEL_W-1:0] sel_d;
  logic             entry_d;

  always_comb begin
    eff = mode_from_ser ? ser_ctl : pin_ctl;
    if (!eff.sleep_n) begin
      mode_d = MODE_SLEEP;
    end else begin
      case ({eff.fm_n, eff.idle_n})
        2'b00:   mode_d = MODE_FM_RX;
        2'b01:   mode_d = MODE_FM_RXTX;
        2'b10:   mode_d = MODE_CDMA_RX;
        default: mode_d = MODE_CDMA_RXTX;
      endcase
    end
    sel_d   = sel_from_ser ? ser_sel : pin_sel;
    entry_d = is_cdma(mode_d) && !is_cdma(mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SLEEP;
      sel_q   <= '0;
      entry_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      entry_q <= entry_d;
    end
  end

endmodule

// File: rtl/serial_mode_ctl.sv
`timescale 1ns/1ps
module serial_mode_ctl
  import smc_pkg::*;
#(
  parameter int DIV_W       = 14,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_latch,
  input  logic             pin_sleep_n,
  input  logic             pin_fm_n,
  input  logic             pin_idle_n,
  input  logic [SEL_W-1:0] pin_aux_sel,
  output logic [DIV_W-1:0] div_ratio,
  output logic             cmp_slow,
  output logic             test_mode,
  output logic             cal_en,
  output logic [2:0]       mode,
  output logic [SEL_W-1:0] aux_sel,
  output logic             cdma_entry
);

  localparam int P_CAL   = 0;
  localparam int P_ASRC  = 1;
  localparam int P_SEL   = 2;
  localparam int P_TEST  = P_SEL + SEL_W;
  localparam int P_FM    = P_TEST + 1;
  localparam int P_IDLE  = P_FM + 1;
  localparam int P_SLEEP = P_IDLE + 1;
  localparam int P_MSRC  = P_SLEEP + 1;
  localparam int P_DIV   = P_MSRC + 1;
  localparam int P_CMP   = P_DIV + DIV_W;
  localparam int WORD_W  = P_CMP + 1;
  localparam int SYNC_W  = 6 + SEL_W;

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [SYNC_W-1:0] raw_in, syn_in;
  assign raw_in = {pin_aux_sel, pin_sleep_n, pin_fm_n, pin_idle_n,
                   ser_latch, ser_data, ser_clk};

  smc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (raw_in),
    .q     (syn_in)
  );

  logic              latch_fire;
  logic [WORD_W-1:0] ctl_word;

  smc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i),
    .sclk_s   (syn_in[0]),
    .sdata_s  (syn_in[1]),
    .slatch_s (syn_in[2]),
    .load     (latch_fire),
    .word_q   (ctl_word)
  );

  mode_ctl_t        ser_ctl, pin_ctl;
  logic             ctl_msrc, ctl_asrc;
  logic [SEL_W-1:0] ctl_sel;
  op_mode_e         mode_e;

  assign ser_ctl  = '{sleep_n: ctl_word[P_SLEEP], fm_n: ctl_word[P_FM],
                      idle_n: ctl_word[P_IDLE]};
  assign pin_ctl  = '{sleep_n: syn_in[5], fm_n: syn_in[4], idle_n: syn_in[3]};
  assign ctl_msrc = ctl_word[P_MSRC];
  assign ctl_asrc = ctl_word[P_ASRC];
  assign ctl_sel  = ctl_word[P_SEL +: SEL_W];

  smc_mode_dec #(.SEL_W(SEL_W)) u_dec (
    .clk           (clk),
    .rst_n         (rst_i),
    .mode_from_ser (ctl_msrc),
    .ser_ctl       (ser_ctl),
    .pin_ctl       (pin_ctl),
    .sel_from_ser  (ctl_asrc),
    .ser_sel       (ctl_sel),
    .pin_sel       (syn_in[6 +: SEL_W]),
    .mode_q        (mode_e),
    .sel_q         (aux_sel),
    .entry_q       (cdma_entry)
  );

  assign mode      = mode_e;
  assign div_ratio = ctl_word[P_DIV +: DIV_W];
  assign cmp_slow  = ctl_word[P_CMP];
  assign test_mode = ctl_word[P_TEST];
  assign cal_en    = ctl_word[P_CAL];

endmodule

// File: rtl/smc_checker.sv
`timescale 1ns/1ps
module smc_checker #(
  parameter int DIV_W = 14,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_i,
  input logic             load,
  input logic             ctl_asrc,
  input logic [SEL_W-1:0] ctl_sel,
  input logic [DIV_W-1:0] div_ratio,
  input logic             cmp_slow,
  input logic             test_mode,
  input logic             cal_en,
  input logic [2:0]       mode,
  input logic [SEL_W-1:0] aux_sel,
  input logic             cdma_entry
);

  a_r9_entry_single: assert property (@(posedge clk) disable iff (!rst_i)
    cdma_entry |=> !cdma_entry);

  a_r9_entry_into_cdma: assert property (@(posedge clk) disable iff (!rst_i)
    cdma_entry |-> (mode[2:1] == 2'b11) && ($past(mode[2:1]) != 2'b11));

  a_r7_legal_mode: assert property (@(posedge clk) disable iff (!rst_i)
    mode[2] || (mode[1:0] == 2'b00));

  a_r3_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_i)
    !load |=> $stable(div_ratio) && $stable(cmp_slow) &&
              $stable(test_mode) && $stable(cal_en));

  a_r8_serial_select: assert property (@(posedge clk) disable iff (!rst_i)
    $past(ctl_asrc) |-> aux_sel == $past(ctl_sel));

endmodule

bind serial_mode_ctl smc_checker #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .load       (latch_fire),
  .ctl_asrc   (ctl_asrc),
  .ctl_sel    (ctl_sel),
  .div_ratio  (div_ratio),
  .cmp_slow   (cmp_slow),
  .test_mode  (test_mode),
  .cal_en     (cal_en),
  .mode       (mode),
  .aux_sel    (aux_sel),
  .cdma_entry (cdma_entry)
);

// File: tb/test_serial_mode_ctl.sv
`timescale 1ns/1ps
module test_serial_mode_ctl;

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_data, ser_latch;
  logic pin_sleep_n, pin_fm_n, pin_idle_n;
  logic [1:0]  pin_aux_sel, aux_sel;
  logic [13:0] div_ratio;
  logic cmp_slow, test_mode, cal_en, cdma_entry;
  logic [2:0] mode;

  always #2.5 clk = ~clk;

  serial_mode_ctl i_serial_mode_ctl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .pin_sleep_n(pin_sleep_n), .pin_fm_n(pin_fm_n),
    .pin_idle_n(pin_idle_n), .pin_aux_sel(pin_aux_sel),
    .div_ratio(div_ratio), .cmp_slow(cmp_slow), .test_mode(test_mode),
    .cal_en(cal_en), .mode(mode), .aux_sel(aux_sel), .cdma_entry(cdma_entry)
  );

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic rst, sclk, sdata, slatch, sl, fm, id;
    logic [1:0] sel;
  } raw_t;
  raw_t hist[$];
  raw_t cur;
  logic [23:0] m_sh = '0, m_word = '0, m_word_old;
  logic [2:0]  m_mode = 3'b000, m_mode_old;
  logic [1:0]  m_aux = 2'b00;
  logic        m_pulse = 1'b0;

  function automatic logic [2:0] dec(logic sl, logic fm, logic id);
    return sl ? {1'b1, fm, id} : 3'b000;
  endfunction

  initial for (int k = 0; k < 4; k++) hist.push_front('0);

  always @(posedge clk) begin
    cur = '{rst: rst_n, sclk: ser_clk, sdata: ser_data, slatch: ser_latch,
            sl: pin_sleep_n, fm: pin_fm_n, id: pin_idle_n, sel: pin_aux_sel};
    hist.push_front(cur);
    if (hist.size() > 6) void'(hist.pop_back());
    if (!(hist[1].rst && hist[2].rst) || !rst_n) begin
      m_sh = '0; m_word = '0; m_mode = 3'b000; m_aux = 2'b00; m_pulse = 1'b0;
    end else begin
      m_word_old = m_word;
      m_mode_old = m_mode;
      if (hist[2].slatch && !hist[3].slatch) m_word = m_sh;
      if (hist[2].sclk && !hist[3].sclk) m_sh = {m_sh[22:0], hist[2].sdata};
      m_mode  = m_word_old[8] ? dec(m_word_old[7], m_word_old[5], m_word_old[6])
                              : dec(hist[2].sl, hist[2].fm, hist[2].id);
      m_aux   = m_word_old[1] ? m_word_old[3:2] : hist[2].sel;
      m_pulse = (m_mode[2:1] == 2'b11) && (m_mode_old[2:1] != 2'b11);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R4 div_ratio", div_ratio, m_word[22:9]);
      check("R4 cmp_slow",  cmp_slow,  m_word[23]);
      check("R4 test_mode", test_mode, m_word[4]);
      check("R4 cal_en",    cal_en,    m_word[0]);
      check("R7 mode",      mode,      m_mode);
      check("R8 aux_sel",   aux_sel,   m_aux);
      check("R9 cdma_entry", cdma_entry, m_pulse);
      if (cdma_entry) pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(logic cmp, logic [13:0] dv, logic msrc,
      logic sl, logic id, logic fm, logic tst, logic [1:0] ad, logic asrc, logic cal);
    return {cmp, dv, msrc, sl, id, fm, tst, ad, asrc, cal};
  endfunction

  task automatic send(input logic [63:0] bits, input int n, input bit latch);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i]; ser_clk = 1'b0; cyc(3);
      ser_clk = 1'b1; cyc(3);
    end
    ser_clk = 1'b0; cyc(3);
    if (latch) begin
      ser_latch = 1'b1; cyc(3);
      ser_latch = 1'b0; cyc(3);
    end
    cyc(6);
  endtask

  task automatic pins(input logic sl, input logic fm, input logic id);
    pin_sleep_n = sl; pin_fm_n = fm; pin_idle_n = id;
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 0; ser_data = 0; ser_latch = 0;
    pins(0, 0, 0); pin_aux_sel = 2'b00;
    cyc(4); rst_n = 1'b1; cyc(5);
    check("R1 mode", mode, 3'b000);
    check("R1 div", div_ratio, 0);
    check("R1 cal", cal_en, 0);
    check("R1 aux", aux_sel, 0);
    check("R1 entry", cdma_entry, 0);

    pins(1, 0, 0); cyc(6);
    check("R5 pin FM rx", mode, 3'b100);
    pins(1, 0, 1); cyc(6);
    check("R7 FM rxtx", mode, 3'b101);

    // latency: change lands before edge e; visible after edge e+2
    pins(1, 1, 0); cyc(2);
    check("R10 old value after 2 edges", mode, 3'b101);
    cyc(1);
    check("R10 new value after 3 edges", mode, 3'b110);
    check("R9 entry pulse", cdma_entry, 1);
    cyc(1);
    check("R9 pulse one cycle", cdma_entry, 0);

    pulses = 0; pins(1, 1, 1); cyc(6); #1;
    check("R9 no pulse cdma to cdma", pulses, 0);
    check("R7 cdma rxtx", mode, 3'b111);
    pins(0, 1, 1); cyc(6);
    check("R7 sleep overrides", mode, 3'b000);
    pulses = 0; pins(1, 1, 1); cyc(6); #1;
    check("R9 pulse from sleep", pulses, 1);

    pin_aux_sel = 2'b10;
    send({40'd0, mk(1, 14'h2A5B, 0, 1, 0, 0, 0, 2'b01, 0, 1)}, 24, 1);
    check("R4 div field", div_ratio, 14'h2A5B);
    check("R4 cmp field", cmp_slow, 1);
    check("R4 cal field", cal_en, 1);
    check("R5 pins still rule", mode, 3'b111);
    check("R8 pin select", aux_sel, 2'b10);

    send({40'd0, mk(0, 14'h0111, 1, 0, 0, 0, 1, 2'b11, 1, 0)}, 24, 0);
    check("R3 no latch div", div_ratio, 14'h2A5B);
    check("R3 no latch cal", cal_en, 1);
    check("R3 no latch mode", mode, 3'b111);

    pulses = 0;
    send({34'd0, 6'b101101, mk(0, 14'h01C3, 1, 1, 1, 0, 1, 2'b11, 1, 0)}, 30, 1);
    check("R2 last 24 bits div", div_ratio, 14'h01C3);
    check("R2 last 24 bits test", test_mode, 1);
    check("R2 last 24 bits cal", cal_en, 0);
    check("R6 serial mode", mode, 3'b101);
    check("R8 serial select", aux_sel, 2'b11);
    pins(0, 0, 0); cyc(6);
    check("R6 pins ignored", mode, 3'b101);

    pulses = 0;
    send({40'd0, mk(0, 14'h01C3, 1, 1, 0, 1, 0, 2'b11, 1, 0)}, 24, 1);
    check("R6 serial cdma rx", mode, 3'b110);
    check("R9 serial entry pulse", pulses, 1);

    send({40'd0, mk(0, 14'h3FFF, 0, 1, 1, 1, 0, 2'b01, 0, 1)}, 24, 1);
    check("R5 back to pins", mode, 3'b000);
    check("R8 back to pin select", aux_sel, 2'b10);
    check("R4 full divider", div_ratio, 14'h3FFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog (all) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule